// File: doc/BRIEF.md
# Reference-counted multicast hash table

The block keeps a 64-bin multicast hash mask for a receive address filter. Software or a control engine issues add, remove and clear commands through a valid/ready handshake, each carrying a 48-bit group address. The block hashes the address to a bin and keeps a use count for that bin. A mask bit is on exactly while its bin has at least one user, so two group addresses that land in the same bin do not disturb each other.

Whenever a command changes the mask, the block writes the new mask to the downstream filter on its own. It first drops the filter's hash enable and receive enable. It then waits until the filter reports both as off. It writes the four 16-bit mask words in ascending order and finally raises both enables again. Commands are held off while this runs.

Top module: `mcast_hash_table`

## Requirements
- R1: After reset the mask is all zero, `cmd_ready`, `hash_en` and `rx_en` are 1, and `wr_valid` is 0.
- R2: The bin index is derived from a CRC-32 with polynomial 0x04C11DB7 and an all-ones preset. The address is fed as six bytes, `cmd_addr[47:40]` first, each byte least significant bit first. Index bit i equals CRC bit 5-i. Mask bit n is `hash_mask[n]`, which is word n/16 at bit n%16.
- R3: An add command (`cmd_op`=2'b01) increments the bin count. It sets the mask bit only when the count was zero, and only that case starts a write-out.
- R4: A remove command (`cmd_op`=2'b10) on a bin with a nonzero count decrements it. The mask bit is cleared, and a write-out started, only when the count reaches zero.
- R5: A remove command on a bin whose count is zero changes neither the mask nor any count, and starts no write-out.
- R6: A clear command (`cmd_op`=2'b11) zeroes all counts and the whole mask. It starts a write-out only if the mask was nonzero.
- R7: Counts are 8 bits wide and saturate at 255. After 256 or more adds, 254 removes keep the bit set and the 255th clears it.
- R8: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low for the whole write-out. `cmd_op`=2'b00 is accepted and has no effect.
- R9: A write-out first drives `hash_en` and `rx_en` low. It issues no word until both `hash_en_rb` and `rx_en_rb` are low. It then drives `wr_valid` for four consecutive cycles with `wr_idx` 0,1,2,3 and `wr_data` equal to that mask word, and raises `hash_en` and `rx_en` after the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 00 none, 01 add, 10 remove, 11 clear |
| cmd_addr | input | 48 | Group address |
| hash_mask | output | 64 | Current mask, bit n is bin n |
| hash_en | output | 1 | Filter hash enable |
| rx_en | output | 1 | Filter receive enable |
| hash_en_rb | input | 1 | Filter reports hash enable state |
| rx_en_rb | input | 1 | Filter reports receive enable state |
| wr_valid | output | 1 | Mask word write strobe |
| wr_idx | output | 2 | Mask word number |
| wr_data | output | 16 | Mask word value |

## Verification
The bench searches for two addresses that share a bin. It checks that the second add and the first remove leave the bit alone and start no write-out. A design that kept only a bit per bin would clear the bin early. A design that refreshed the filter on every command would show extra write-outs. A remove on an empty bin is checked so that a design whose count underflows would set up a wrong later clear. The bench also adds 300 times to one bin to catch counts that wrap and clear the bit too soon. It holds the enable readback high to prove that no word is written before the filter reports it is off.

// File: rtl/mch_pkg.sv
package mch_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_ADD   = 2'b01,
      OP_REM   = 2'b10,
      OP_CLEAR = 2'b11
   } mch_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DROP  = 2'd1,
      SQ_WRITE = 2'd2
   } mch_seq_e;
endpackage

// File: rtl/mch_hash.sv
module mch_hash #(
   parameter int ADDR_W = 48,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int NBYTES = ADDR_W / 8;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;

   initial begin
      if (ADDR_W % 8 != 0) $error("mch_hash: ADDR_W must be whole bytes");
      if (IDX_W > 32) $error("mch_hash: IDX_W too wide");
   end

   logic [31:0] crc;

   always_comb begin
      logic fb;
      crc = '1;
      for (int j = 0; j < NBYTES; j++) begin
         for (int b = 0; b < 8; b++) begin
            fb  = crc[31] ^ addr[ADDR_W-8-8*j+b];
            crc = {crc[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
         end
      end
   end

   generate
      for (genvar i = 0; i < IDX_W; i++) begin : g_rev
         assign idx[i] = crc[IDX_W-1-i];
      end
   endgenerate
endmodule

// File: rtl/mch_bins.sv
module mch_bins
   import mch_pkg::*;
#(
   parameter int BINS  = 64,
   parameter int CNT_W = 8,
   parameter int IDX_W = $clog2(BINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  mch_op_e          op,
   input  logic [IDX_W-1:0] idx,
   output logic [BINS-1:0]  mask,
   output logic             mask_chg
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt [BINS];
   logic [CNT_W-1:0] cnt_sel;

   generate
      for (genvar i = 0; i < BINS; i++) begin : g_bin
         logic hit;
         assign hit = fire && (idx == IDX_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt[i]  <= '0;
               mask[i] <= 1'b0;
            end else if (fire && op == OP_CLEAR) begin
               cnt[i]  <= '0;
               mask[i] <= 1'b0;
            end else if (hit && op == OP_ADD) begin
               if (cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + CNT_ONE;
               mask[i] <= 1'b1;
            end else if (hit && op == OP_REM && cnt[i] != '0) begin
               cnt[i] <= cnt[i] - CNT_ONE;
               if (cnt[i] == CNT_ONE) mask[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign cnt_sel = cnt[idx];

   always_comb begin
      unique case (op)
         OP_ADD:   mask_chg = (cnt_sel == '0);
         OP_REM:   mask_chg = (cnt_sel == CNT_ONE);
         OP_CLEAR: mask_chg = |mask;
         default:  mask_chg = 1'b0;
      endcase
   end
endmodule

// File: rtl/mch_seq.sv
module mch_seq
   import mch_pkg::*;
#(
   parameter int BINS   = 64,
   parameter int WORD_W = 16,
   parameter int NWORDS = BINS / WORD_W,
   parameter int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BINS-1:0]   mask,
   input  logic              hash_en_rb,
   input  logic              rx_en_rb,
   output logic              busy,
   output logic              hash_en,
   output logic              rx_en,
   output logic              wr_valid,
   output logic [WIDX_W-1:0] wr_idx,
   output logic [WORD_W-1:0] wr_data
);
   localparam logic [WIDX_W-1:0] LAST = WIDX_W'(NWORDS - 1);

   mch_seq_e          state;
   logic [WIDX_W-1:0] widx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         widx    <= '0;
         hash_en <= 1'b1;
         rx_en   <= 1'b1;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) begin
               state   <= SQ_DROP;
               hash_en <= 1'b0;
               rx_en   <= 1'b0;
            end
            SQ_DROP: if (!hash_en_rb && !rx_en_rb) begin
               state <= SQ_WRITE;
               widx  <= '0;
            end
            SQ_WRITE: begin
               if (widx == LAST) begin
                  state   <= SQ_IDLE;
                  hash_en <= 1'b1;
                  rx_en   <= 1'b1;
               end
               widx <= widx + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state != SQ_IDLE);
   assign wr_valid = (state == SQ_WRITE);
   assign wr_idx   = widx;
   assign wr_data  = mask[widx*WORD_W +: WORD_W];
endmodule

// File: rtl/mcast_hash_table.sv
module mcast_hash_table
   import mch_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int BINS   = 64,
   parameter int CNT_W  = 8,
   parameter int WORD_W = 16,
   localparam int IDX_W  = $clog2(BINS),
   localparam int NWORDS = BINS / WORD_W,
   localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic [BINS-1:0]   hash_mask,
   output logic              hash_en,
   output logic              rx_en,
   input  logic              hash_en_rb,
   input  logic              rx_en_rb,
   output logic              wr_valid,
   output logic [WIDX_W-1:0] wr_idx,
   output logic [WORD_W-1:0] wr_data
);
   initial begin
      if (BINS != (1 << IDX_W)) $error("mcast_hash_table: BINS must be a power of two");
      if (BINS % WORD_W != 0) $error("mcast_hash_table: BINS must be whole words");
      if (CNT_W < 2) $error("mcast_hash_table: CNT_W too small");
   end

   logic             fire, chg, busy;
   logic [IDX_W-1:0] idx;
   mch_op_e          op;

   assign op        = mch_op_e'(cmd_op);
   assign cmd_ready = !busy;
   assign fire      = cmd_valid && cmd_ready;

   mch_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
      .addr (cmd_addr),
      .idx  (idx)
   );

   mch_bins #(.BINS(BINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bins (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .op       (op),
      .idx      (idx),
      .mask     (hash_mask),
      .mask_chg (chg)
   );

   mch_seq #(.BINS(BINS), .WORD_W(WORD_W), .NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fire && chg),
      .mask       (hash_mask),
      .hash_en_rb (hash_en_rb),
      .rx_en_rb   (rx_en_rb),
      .busy       (busy),
      .hash_en    (hash_en),
      .rx_en      (rx_en),
      .wr_valid   (wr_valid),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data)
   );
endmodule

// File: rtl/mch_checker.sv
module mch_checker #(
   parameter int BINS   = 64,
   parameter int WORD_W = 16,
   parameter int WIDX_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [BINS-1:0]   hash_mask,
   input logic              hash_en,
   input logic              rx_en,
   input logic              hash_en_rb,
   input logic              rx_en_rb,
   input logic              wr_valid,
   input logic [WIDX_W-1:0] wr_idx,
   input logic [WORD_W-1:0] wr_data
);
   localparam logic [WIDX_W-1:0] LAST = WIDX_W'(BINS / WORD_W - 1);

   // R8: no command is taken while words are being written
   a_r8_ready_low_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !cmd_ready);

   // R8: mask moves only after an accepted command
   a_r8_mask_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> $stable(hash_mask));

   // R9: both enables are off while words go out
   a_r9_enables_off: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (!hash_en && !rx_en));

   // R9: words go out in ascending order, back to back
   a_r9_word_order: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_idx != LAST) |=> (wr_valid && wr_idx == $past(wr_idx) + 1'b1));

   // R9: the first word follows a cleared readback
   a_r9_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> (wr_idx == '0 && $past(!hash_en_rb && !rx_en_rb)));

   // R9: enables come back right after the last word
   a_r9_reenable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_valid) |-> (hash_en && rx_en));
endmodule

bind mcast_hash_table mch_checker #(.BINS(BINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_mch_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .hash_mask  (hash_mask),
   .hash_en    (hash_en),
   .rx_en      (rx_en),
   .hash_en_rb (hash_en_rb),
   .rx_en_rb   (rx_en_rb),
   .wr_valid   (wr_valid),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data)
);

// File: tb/test_mcast_hash_table.sv
`timescale 1ns/100ps
module test_mcast_hash_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'b00;
   logic [47:0] cmd_addr = '0;
   logic [63:0] hash_mask;
   logic        hash_en, rx_en;
   logic        hash_en_rb = 1'b1, rx_en_rb = 1'b1;
   logic        wr_valid;
   logic [1:0]  wr_idx;
   logic [15:0] wr_data;

   int total = 0, bad = 0;
   logic hold_rb = 1'b0;
   logic done = 1'b0;

   logic [7:0]  exp_cnt [64];
   logic [63:0] exp_mask = '0;
   logic [63:0] shadow = '0;
   int          writes = 0, seqs = 0, next_idx = 0;

   always #2.5 clk = ~clk;

   mcast_hash_table i_mcast_hash_table (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .hash_mask(hash_mask),
      .hash_en(hash_en), .rx_en(rx_en), .hash_en_rb(hash_en_rb), .rx_en_rb(rx_en_rb),
      .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   // downstream filter: readback follows the enables one cycle later
   always @(posedge clk) begin
      hash_en_rb <= hold_rb ? 1'b1 : hash_en;
      rx_en_rb   <= hold_rb ? 1'b1 : rx_en;
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // write monitor
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         writes++;
         check(int'(wr_idx) == next_idx, "R9 word order", 64'(wr_idx), 64'(next_idx));
         check(!hash_en && !rx_en, "R9 enables low in write", {hash_en, rx_en}, 0);
         shadow[wr_idx*16 +: 16] = wr_data;
         if (wr_idx == 2'd3) begin
            next_idx = 0;
            seqs++;
         end else next_idx = next_idx + 1;
      end
   end

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic [5:0] r;
      for (int k = 0; k < 48; k++) begin
         logic d, fb;
         d  = a[40 - 8*(k/8) + (k%8)];
         fb = c[31] ^ d;
         c  = fb ? ({c[30:0], 1'b0} ^ 32'h04C1_1DB7) : {c[30:0], 1'b0};
      end
      for (int i = 0; i < 6; i++) r[i] = c[5-i];
      return r;
   endfunction

   // apply one command, update the model, and check mask and write-out behaviour
   task automatic do_cmd(input logic [1:0] op, input logic [47:0] a, input string tag);
      int n;
      bit want_seq;
      int s0;
      n = ref_idx(a);
      want_seq = 1'b0;
      case (op)
         2'b01: begin
            want_seq = (exp_cnt[n] == 0);
            if (exp_cnt[n] != 8'hFF) exp_cnt[n] = exp_cnt[n] + 1;
            exp_mask[n] = 1'b1;
         end
         2'b10: if (exp_cnt[n] != 0) begin
            want_seq = (exp_cnt[n] == 1);
            exp_cnt[n] = exp_cnt[n] - 1;
            if (exp_cnt[n] == 0) exp_mask[n] = 1'b0;
         end
         2'b11: begin
            want_seq = (exp_mask != 0);
            for (int i = 0; i < 64; i++) exp_cnt[i] = 0;
            exp_mask = '0;
         end
         default: ;
      endcase
      while (!cmd_ready) @(negedge clk);
      s0 = seqs;
      cmd_op = op; cmd_addr = a; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(hash_mask == exp_mask, {tag, " mask"}, hash_mask, exp_mask);
      if (want_seq) begin
         for (int t = 0; t < 40 && !(seqs != s0 && cmd_ready); t++) @(negedge clk);
         check(seqs == s0 + 1, {tag, " write-out count"}, 64'(seqs - s0), 1);
         check(shadow == exp_mask, {tag, " written words"}, shadow, exp_mask);
         check(hash_en && rx_en, {tag, " enables back"}, {hash_en, rx_en}, 2'b11);
      end else begin
         bit rdy_ok = 1'b1;
         for (int t = 0; t < 8; t++) begin
            if (!cmd_ready) rdy_ok = 1'b0;
            @(negedge clk);
         end
         check(seqs == s0 && rdy_ok, {tag, " no write-out"}, 64'(seqs - s0), 0);
      end
   endtask

   task automatic t_reset;
      check(hash_mask == 0, "R1 mask", hash_mask, 0);
      check(cmd_ready && hash_en && rx_en && !wr_valid, "R1 outputs",
            {cmd_ready, hash_en, rx_en, wr_valid}, 4'b1110);
   endtask

   task automatic t_shared_bin;
      logic [47:0] a, b;
      a = 48'h0100_5E00_0001;
      b = a;
      for (int k = 1; k < 4096; k++) begin
         b = a + 48'(k);
         if (ref_idx(b) == ref_idx(a)) break;
      end
      do_cmd(2'b01, a, "R2 R3 first add");
      check(hash_mask == (64'd1 << ref_idx(a)), "R2 bin position", hash_mask, 64'd1 << ref_idx(a));
      do_cmd(2'b01, b, "R3 shared-bin add");
      do_cmd(2'b10, a, "R4 remove keeps bit");
      do_cmd(2'b10, b, "R4 last remove clears");
   endtask

   task automatic t_remove_empty;
      do_cmd(2'b01, 48'h3333_0000_00AA, "R3 add");
      do_cmd(2'b10, 48'h0100_5E7F_FFFA, "R5 remove on empty bin");
      do_cmd(2'b10, 48'h3333_0000_00AA, "R4 remove");
      do_cmd(2'b10, 48'h3333_0000_00AA, "R5 second remove on empty bin");
   endtask

   task automatic t_nop;
      do_cmd(2'b01, 48'h0100_5E12_3456, "R3 add");
      do_cmd(2'b00, 48'h0100_5E00_00FB, "R8 none op");
   endtask

   task automatic t_hold;
      int w0;
      logic [47:0] a;
      a = 48'h0100_5E01_0203;
      if (exp_cnt[ref_idx(a)] != 0) a = 48'h0100_5E09_0807;
      hold_rb = 1'b1;
      w0 = writes;
      while (!cmd_ready) @(negedge clk);
      cmd_op = 2'b01; cmd_addr = a; cmd_valid = 1'b1;
      exp_cnt[ref_idx(a)] = exp_cnt[ref_idx(a)] + 1;
      exp_mask[ref_idx(a)] = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      check(writes == w0, "R9 no word before readback clear", 64'(writes - w0), 0);
      check(!hash_en && !rx_en, "R9 enables dropped", {hash_en, rx_en}, 0);
      check(!cmd_ready, "R8 ready low during write-out", 64'(cmd_ready), 0);
      hold_rb = 1'b0;
      for (int t = 0; t < 40 && !cmd_ready; t++) @(negedge clk);
      check(writes == w0 + 4, "R9 four words", 64'(writes - w0), 4);
      check(shadow == exp_mask, "R9 words match mask", shadow, exp_mask);
      check(hash_en && rx_en, "R9 re-enabled", {hash_en, rx_en}, 2'b11);
   endtask

   task automatic t_saturate;
      logic [47:0] a;
      a = 48'h0100_5E44_5566;
      for (int i = 0; i < 300; i++) do_cmd(2'b01, a, "R7 add");
      for (int i = 0; i < 254; i++) do_cmd(2'b10, a, "R7 remove");
      check(hash_mask[ref_idx(a)] == 1'b1, "R7 bit kept after 254 removes", 64'(hash_mask[ref_idx(a)]), 1);
      do_cmd(2'b10, a, "R7 final remove");
      check(hash_mask[ref_idx(a)] == 1'b0, "R7 bit cleared", 64'(hash_mask[ref_idx(a)]), 0);
   endtask

   task automatic t_clear;
      logic [47:0] a;
      a = 48'h0100_5E22_1100;
      do_cmd(2'b01, a, "R6 add");
      do_cmd(2'b01, a, "R6 add again");
      do_cmd(2'b11, 48'h0, "R6 clear");
      check(hash_mask == 0, "R6 mask zero", hash_mask, 0);
      do_cmd(2'b11, 48'h0, "R6 clear on empty mask");
      do_cmd(2'b01, a, "R6 add after clear");
      do_cmd(2'b10, a, "R6 count was reset");
   endtask

   initial begin
      for (int i = 0; i < 64; i++) exp_cnt[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shared_bin();
      t_remove_empty();
      t_nop();
      t_hold();
      t_clear();
      t_saturate();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800us;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule